// File: doc/BRIEF.md
# Precision Time Counter with Fine and Coarse Update

This block keeps the local notion of time for a network timestamping unit. It holds a seconds field and a sub-second field that counts in binary fractions of a second, advancing on every clock of the timestamp clock domain. Two update methods are available and can be swapped at runtime. In fine mode, a 32-bit addend is summed into an accumulator every clock, and the sub-second field steps by its increment only when that sum carries out. Software trims the rate by changing the addend, which suits a follower clock that a servo corrects often. In coarse mode the accumulator is left alone and the increment is added on every clock. This allows an increment of a single clock period, but nothing inside the block adjusts the rate, so it must be corrected from outside, for example from a pulse-per-second reference.

Software drives the block through a plain write port with five registers. A control register holds the mode bit and two self-clearing strobe bits: one loads a programmed start time, and one moves a staged addend into use. A separate capture input latches both time fields together, so a reader never sees a seconds value and a sub-second value from different sides of a rollover.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, both time fields, both captured fields, the accumulator, the increment and the active addend are zero, and the mode is fine (bit 0 of the control register at address 0 reads as 0). Time therefore does not move until software programs the block.
- R2: In fine mode, the active addend is added into a 32-bit accumulator on every clock that is not an initialize cycle. On each clock where that sum carries out of bit 31, the sub-second field advances by the increment. On the other clocks it holds.
- R3: In coarse mode (control bit 0 = 1), the sub-second field advances by the increment on every clock that is not an initialize cycle. The addend and the accumulator have no effect on the time.
- R4: The sub-second field is 31 bits wide and rolls over in binary. When the sum of the field and the increment reaches 2^31, the field keeps the sum modulo 2^31 and the seconds field goes up by one in the same clock.
- R5: A write to address 2 only stages a new addend. A control write with bit 2 set copies the staged value into use, and the copy takes effect from the next clock on. The accumulator keeps its value through the copy.
- R6: A control write with bit 1 set loads the seconds field from address 3 and the sub-second field from address 4, and clears the accumulator, on that clock edge. The load takes priority over any increment in the same cycle.
- R7: On a clock where the capture input is high, both captured fields take the time fields' values from before that edge, in the same cycle. On any other clock, the captured fields hold.
- R8: Apart from an initialize load, the time never goes backwards. This includes clocks where the mode, the increment or the addend changes.
- R9: A write to the increment register (address 1) or to the mode bit takes effect from the clock after the write. Switching modes neither clears nor disturbs the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Register address: 0 control, 1 increment, 2 staged addend, 3 start seconds, 4 start sub-second |
| wrData | input | 32 | Register write data |
| captureReq | input | 1 | Latch a snapshot of the time |
| nowSec | output | 32 | Live seconds field |
| nowSub | output | 31 | Live sub-second field |
| capSec | output | 32 | Captured seconds |
| capSub | output | 31 | Captured sub-second |

## Verification
The monotonic-time property assumes that the seconds field never reaches all ones. The stimulus loads only small start seconds, so the counter stays far from that value. The coarse-mode progress property assumes the increment is narrower than the sub-second field, so one step can never wrap the field back to the same value. The default widths ensure this. The minimum increment that fine mode needs, two clock periods, is left to software and is not assumed by any property. The stimulus uses increments large enough to make each step visible.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [2:0] {
    REG_CTRL     = 3'd0,
    REG_INCR     = 3'd1,
    REG_ADDEND   = 3'd2,
    REG_INIT_SEC = 3'd3,
    REG_INIT_SUB = 3'd4
  } regAddr_e;

  localparam int CTRL_COARSE_BIT = 0;
  localparam int CTRL_LOAD_BIT   = 1;
  localparam int CTRL_ADDUPD_BIT = 2;

  typedef struct packed {
    logic loadInit;
    logic addendUpd;
    logic capture;
  } ptcStrobe_t;

endpackage

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
  import ptc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int SUB_W  = 31,
  parameter int ACC_W  = 32,
  parameter int INC_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              captureReq,
  output ptcStrobe_t        strb,
  output logic              coarseMode,
  output logic [INC_W-1:0]  subIncr,
  output logic [ACC_W-1:0]  stagedAddend,
  output logic [SEC_W-1:0]  initSec,
  output logic [SUB_W-1:0]  initSub
);

  logic ctrlHit;
  logic incrHit;
  logic addHit;
  logic secHit;
  logic subHit;
  logic unusedBits;

  always_comb begin
    ctrlHit = wrEn && (wrAddr == REG_CTRL);
    incrHit = wrEn && (wrAddr == REG_INCR);
    addHit  = wrEn && (wrAddr == REG_ADDEND);
    secHit  = wrEn && (wrAddr == REG_INIT_SEC);
    subHit  = wrEn && (wrAddr == REG_INIT_SUB);
  end

  always_comb begin
    strb.loadInit  = ctrlHit && wrData[CTRL_LOAD_BIT];
    strb.addendUpd = ctrlHit && wrData[CTRL_ADDUPD_BIT];
    strb.capture   = captureReq;
  end

  assign unusedBits = ^wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coarseMode <= 1'b0;
    end else if (ctrlHit) begin
      coarseMode <= wrData[CTRL_COARSE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subIncr <= '0;
    end else if (incrHit) begin
      subIncr <= wrData[INC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedAddend <= '0;
    end else if (addHit) begin
      stagedAddend <= wrData[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initSec <= '0;
      initSub <= '0;
    end else begin
      if (secHit) initSec <= wrData[SEC_W-1:0];
      if (subHit) initSub <= wrData[SUB_W-1:0];
    end
  end

endmodule

// File: rtl/ptc_datapath.sv
module ptc_datapath
  import ptc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int ACC_W = 32,
  parameter int INC_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ptcStrobe_t       strb,
  input  logic             coarseMode,
  input  logic [INC_W-1:0] subIncr,
  input  logic [ACC_W-1:0] stagedAddend,
  input  logic [SEC_W-1:0] initSec,
  input  logic [SUB_W-1:0] initSub,
  output logic [ACC_W-1:0] activeAddend,
  output logic [SEC_W-1:0] nowSec,
  output logic [SUB_W-1:0] nowSub,
  output logic [SEC_W-1:0] capSec,
  output logic [SUB_W-1:0] capSub
);

  localparam int ACC_SUM_W = ACC_W + 1;
  localparam int SUB_SUM_W = SUB_W + 1;

  logic [ACC_W-1:0]     accReg;
  logic [ACC_SUM_W-1:0] accSum;
  logic [SUB_SUM_W-1:0] subSum;
  logic                 stepEn;
  logic                 secCarry;

  always_comb begin
    accSum   = {1'b0, accReg} + {1'b0, activeAddend};
    stepEn   = coarseMode ? 1'b1 : accSum[ACC_W];
    subSum   = {1'b0, nowSub} + SUB_SUM_W'(subIncr);
    secCarry = subSum[SUB_W];
  end

  // Accumulator: frozen in coarse mode so a later return to fine mode resumes cleanly
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
    end else if (strb.loadInit) begin
      accReg <= '0;
    end else if (!coarseMode) begin
      accReg <= accSum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeAddend <= '0;
    end else if (strb.addendUpd) begin
      activeAddend <= stagedAddend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowSec <= '0;
      nowSub <= '0;
    end else if (strb.loadInit) begin
      nowSec <= initSec;
      nowSub <= initSub;
    end else if (stepEn) begin
      nowSub <= subSum[SUB_W-1:0];
      if (secCarry) nowSec <= nowSec + SEC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capSec <= '0;
      capSub <= '0;
    end else if (strb.capture) begin
      capSec <= nowSec;
      capSub <= nowSub;
    end
  end

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int SUB_W  = 31,
  parameter int ACC_W  = 32,
  parameter int INC_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              captureReq,
  output logic [SEC_W-1:0]  nowSec,
  output logic [SUB_W-1:0]  nowSub,
  output logic [SEC_W-1:0]  capSec,
  output logic [SUB_W-1:0]  capSub
);

  ptcStrobe_t       strb;
  logic             coarseMode;
  logic [INC_W-1:0] subIncr;
  logic [ACC_W-1:0] stagedAddend;
  logic [ACC_W-1:0] activeAddend;
  logic [SEC_W-1:0] initSec;
  logic [SUB_W-1:0] initSub;

  ptc_ctrl #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .SUB_W(SUB_W), .ACC_W(ACC_W), .INC_W(INC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .captureReq(captureReq), .strb(strb), .coarseMode(coarseMode),
    .subIncr(subIncr), .stagedAddend(stagedAddend),
    .initSec(initSec), .initSub(initSub)
  );

  ptc_datapath #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .ACC_W(ACC_W), .INC_W(INC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .coarseMode(coarseMode),
    .subIncr(subIncr), .stagedAddend(stagedAddend),
    .initSec(initSec), .initSub(initSub), .activeAddend(activeAddend),
    .nowSec(nowSec), .nowSub(nowSub), .capSec(capSec), .capSub(capSub)
  );

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
  import ptc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int ACC_W = 32,
  parameter int INC_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input ptcStrobe_t       strb,
  input logic             coarseMode,
  input logic [INC_W-1:0] subIncr,
  input logic [ACC_W-1:0] activeAddend,
  input logic [SEC_W-1:0] initSec,
  input logic [SUB_W-1:0] initSub,
  input logic [SEC_W-1:0] nowSec,
  input logic [SUB_W-1:0] nowSub,
  input logic [SEC_W-1:0] capSec,
  input logic [SUB_W-1:0] capSub
);

  // R2: fine mode with a zero addend never carries, so time holds
  assert_fine_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!coarseMode && !strb.loadInit && activeAddend == '0)
      |=> ($stable(nowSub) && $stable(nowSec)));

  // R3: coarse mode moves the sub-second field on every clock
  assert_coarse_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (coarseMode && !strb.loadInit && subIncr != '0) |=> (nowSub != $past(nowSub)));

  // R4: seconds move by at most one per clock outside a load
  assert_sec_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadInit) |=> (nowSec == $past(nowSec) || nowSec == $past(nowSec) + SEC_W'(1)));

  // R6: a load places the programmed start time, with no increment on top
  assert_init_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadInit |=> (nowSec == $past(initSec) && nowSub == $past(initSub)));

  // R7: capture takes the pre-edge time of both fields together
  assert_capture_take_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (capSec == $past(nowSec) && capSub == $past(nowSub)));

  // R7: the snapshot holds without a capture
  assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(capSec) && $stable(capSub)));

  // R8: time never runs backwards outside a load
  assert_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadInit && nowSec != '1)
      |=> (nowSec > $past(nowSec) || (nowSec == $past(nowSec) && nowSub >= $past(nowSub))));

endmodule

bind ptp_time_counter ptc_checker #(
  .SEC_W(SEC_W), .SUB_W(SUB_W), .ACC_W(ACC_W), .INC_W(INC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .coarseMode(coarseMode),
  .subIncr(subIncr), .activeAddend(activeAddend),
  .initSec(initSec), .initSub(initSub),
  .nowSec(nowSec), .nowSub(nowSub), .capSec(capSec), .capSub(capSub)
);

// File: tb/ptp_time_counter_tb_top.sv
module ptp_time_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SEC_W = 32;
  localparam int SUB_W = 31;
  localparam int ACC_W = 32;
  localparam int INC_W = 24;
  localparam int VEC_W = 49;
  localparam int NVEC  = 30;

  localparam logic [1:0] K_WR  = 2'd0;
  localparam logic [1:0] K_RUN = 2'd1;
  localparam logic [1:0] K_CAP = 2'd2;

  // {kind[48:47], addr[46:44], data[43:12], reps[11:4], req[3:0]}
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {K_WR,  3'd1, 32'h0000_0005, 8'd0,  4'd1},  // R1 increment only
    {K_RUN, 3'd0, 32'h0,         8'd4,  4'd1},  // R1 fine default, zero addend: frozen
    {K_WR,  3'd1, 32'h0000_0014, 8'd0,  4'd2},
    {K_WR,  3'd2, 32'h8000_0000, 8'd0,  4'd2},
    {K_WR,  3'd0, 32'h0000_0004, 8'd0,  4'd2},
    {K_RUN, 3'd0, 32'h0,         8'd10, 4'd2},  // R2 carry every other clock
    {K_WR,  3'd2, 32'h4000_0000, 8'd0,  4'd5},
    {K_RUN, 3'd0, 32'h0,         8'd5,  4'd5},  // R5 staged only: rate unchanged
    {K_WR,  3'd0, 32'h0000_0004, 8'd0,  4'd5},
    {K_RUN, 3'd0, 32'h0,         8'd9,  4'd5},  // R5 new rate, accumulator kept
    {K_WR,  3'd0, 32'h0000_0001, 8'd0,  4'd3},
    {K_RUN, 3'd0, 32'h0,         8'd7,  4'd3},  // R3 every clock
    {K_WR,  3'd2, 32'hFFFF_FFFF, 8'd0,  4'd3},
    {K_WR,  3'd0, 32'h0000_0005, 8'd0,  4'd3},
    {K_RUN, 3'd0, 32'h0,         8'd4,  4'd3},  // R3 addend ignored
    {K_WR,  3'd3, 32'h0000_0005, 8'd0,  4'd4},
    {K_WR,  3'd4, 32'h7FFF_FF00, 8'd0,  4'd4},
    {K_WR,  3'd1, 32'h0000_0040, 8'd0,  4'd4},
    {K_WR,  3'd0, 32'h0000_0003, 8'd0,  4'd4},
    {K_RUN, 3'd0, 32'h0,         8'd3,  4'd4},  // R4 just before wrap
    {K_RUN, 3'd0, 32'h0,         8'd2,  4'd4},  // R4 wrapped into seconds
    {K_WR,  3'd0, 32'h0000_0000, 8'd0,  4'd9},
    {K_RUN, 3'd0, 32'h0,         8'd6,  4'd9},  // R9 back to fine
    {K_WR,  3'd0, 32'h0000_0001, 8'd0,  4'd9},
    {K_RUN, 3'd0, 32'h0,         8'd3,  4'd9},
    {K_CAP, 3'd0, 32'h0,         8'd0,  4'd7},  // R7 snapshot
    {K_RUN, 3'd0, 32'h0,         8'd5,  4'd7},  // R7 snapshot held
    {K_WR,  3'd4, 32'h7FFF_FFF0, 8'd0,  4'd4},
    {K_WR,  3'd0, 32'h0000_0002, 8'd0,  4'd4},
    {K_RUN, 3'd0, 32'h0,         8'd4,  4'd4}   // R4 fine-mode wrap
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic             wrEn;
  logic [2:0]       wrAddr;
  logic [31:0]      wrData;
  logic             captureReq;
  logic [SEC_W-1:0] nowSec;
  logic [SUB_W-1:0] nowSub;
  logic [SEC_W-1:0] capSec;
  logic [SUB_W-1:0] capSub;

  int checks = 0;
  int errors = 0;

  logic [SEC_W-1:0] mSec, mCapSec, mInitSec;
  logic [SUB_W-1:0] mSub, mCapSub, mInitSub;
  logic [ACC_W-1:0] mAcc, mAdd, mPend;
  logic [INC_W-1:0] mInc;
  logic             mCoarse;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_time_counter dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .captureReq(captureReq), .nowSec(nowSec), .nowSub(nowSub),
    .capSec(capSec), .capSub(capSub)
  );

  task automatic modelReset();
    mSec = '0; mSub = '0; mCapSec = '0; mCapSub = '0; mInitSec = '0; mInitSub = '0;
    mAcc = '0; mAdd = '0; mPend = '0; mInc = '0; mCoarse = 1'b0;
  endtask

  task automatic modelStep(input logic we, input logic [2:0] addr,
                           input logic [31:0] data, input logic cap);
    logic [ACC_W:0] aSum;
    logic [SUB_W:0] sSum;
    logic stepNow;
    logic ld;
    logic upd;
    ld  = we && addr == 3'd0 && data[1];
    upd = we && addr == 3'd0 && data[2];
    if (cap) begin mCapSec = mSec; mCapSub = mSub; end
    if (ld) begin
      mSec = mInitSec; mSub = mInitSub; mAcc = '0;
    end else begin
      if (mCoarse) stepNow = 1'b1;
      else begin
        aSum = {1'b0, mAcc} + {1'b0, mAdd};
        mAcc = aSum[ACC_W-1:0];
        stepNow = aSum[ACC_W];
      end
      if (stepNow) begin
        sSum = {1'b0, mSub} + (SUB_W+1)'(mInc);
        mSub = sSum[SUB_W-1:0];
        if (sSum[SUB_W]) mSec = mSec + 1;
      end
    end
    if (upd) mAdd = mPend;
    if (we) begin
      case (addr)
        3'd0: mCoarse = data[0];
        3'd1: mInc = data[INC_W-1:0];
        3'd2: mPend = data;
        3'd3: mInitSec = data;
        3'd4: mInitSub = data[SUB_W-1:0];
        default: ;
      endcase
    end
  endtask

  // One clock: drive at the falling edge, step the model, observe at the next falling edge
  task automatic stepCycle(input logic we, input logic [2:0] addr,
                           input logic [31:0] data, input logic cap);
    logic [SEC_W+SUB_W-1:0] prevT;
    logic ld;
    prevT = {nowSec, nowSub};
    ld = we && addr == 3'd0 && data[1];
    wrEn = we; wrAddr = addr; wrData = data; captureReq = cap;
    modelStep(we, addr, data, cap);
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; captureReq = 1'b0;
    if (!ld) begin
      checks++;
      if ({nowSec, nowSub} < prevT) begin
        errors++;
        $display("FAIL R8 time went back: actual %0h expected at least %0h",
                 {nowSec, nowSub}, prevT);
      end
    end
  endtask

  task automatic checkAll(input int req);
    checks++;
    if (nowSec !== mSec || nowSub !== mSub) begin
      errors++;
      $display("FAIL R%0d time actual %0h.%0h expected %0h.%0h", req, nowSec, nowSub, mSec, mSub);
    end
    checks++;
    if (capSec !== mCapSec || capSub !== mCapSub) begin
      errors++;
      $display("FAIL R%0d snapshot actual %0h.%0h expected %0h.%0h",
               req, capSec, capSub, mCapSec, mCapSub);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; captureReq = 1'b0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkAll(1);  // R1 reset state

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  kind;
      logic [2:0]  addr;
      logic [31:0] data;
      logic [7:0]  reps;
      logic [3:0]  req;
      {kind, addr, data, reps, req} = VECS[i];
      if (kind == K_WR) begin
        stepCycle(1'b1, addr, data, 1'b0);
      end else if (kind == K_RUN) begin
        for (int k = 0; k < int'(reps); k++) stepCycle(1'b0, 3'd0, 32'h0, 1'b0);
        checkAll(int'(req));
      end else begin
        stepCycle(1'b0, 3'd0, 32'h0, 1'b1);
        checkAll(int'(req));
      end
    end

    // R6: load beats the increment in the same cycle (coarse mode, nonzero increment)
    stepCycle(1'b1, 3'd3, 32'h0000_0009, 1'b0);
    stepCycle(1'b1, 3'd4, 32'h0000_0100, 1'b0);
    stepCycle(1'b1, 3'd1, 32'h0000_0010, 1'b0);
    stepCycle(1'b1, 3'd0, 32'h0000_0003, 1'b0);
    checks++;
    if (nowSec !== 32'd9 || nowSub !== 31'h100) begin
      errors++;
      $display("FAIL R6 load actual %0h.%0h expected 9.100", nowSec, nowSub);
    end
    stepCycle(1'b0, 3'd0, 32'h0, 1'b0);
    checks++;
    if (nowSub !== 31'h110) begin
      errors++;
      $display("FAIL R6 step after load actual %0h expected 110", nowSub);
    end
    checkAll(6);

    // R7: capture in the same cycle as a load takes the pre-load time
    stepCycle(1'b0, 3'd0, 32'h0, 1'b0);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 32'h3; captureReq = 1'b1;
    modelStep(1'b1, 3'd0, 32'h3, 1'b1);
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; captureReq = 1'b0;
    checkAll(7);

    // R9: accumulator kept across a coarse interval, fine mode resumes from it
    stepCycle(1'b1, 3'd2, 32'h6000_0000, 1'b0);
    stepCycle(1'b1, 3'd0, 32'h0000_0004, 1'b0);
    stepCycle(1'b0, 3'd0, 32'h0, 1'b0);
    stepCycle(1'b1, 3'd0, 32'h0000_0001, 1'b0);
    for (int k = 0; k < 3; k++) stepCycle(1'b0, 3'd0, 32'h0, 1'b0);
    stepCycle(1'b1, 3'd0, 32'h0000_0000, 1'b0);
    for (int k = 0; k < 5; k++) stepCycle(1'b0, 3'd0, 32'h0, 1'b0);
    checkAll(9);

    finishRun();
  end

endmodule